// File: doc/BRIEF.md
# Priority-Floor Port Power Arbiter

This block decides, for a group of power-sourcing ports (eight by default), whether each port may be switched on after its load has been detected and whether a port that is already on may keep its power. Every port carries a two-bit priority level from the host. Two global floors, also two bits each, come from the host. The grant floor gates new power-up after a detection. The keep floor gates staying powered. Register values arrive as plain inputs. Detection, current sensing and the host bus live elsewhere.

Each port runs a three-state machine. The states are IDLE, POWERED and DENIED. The transitions are named as follows:
- IDLE to POWERED is *grant*.
- IDLE to DENIED is *refuse*.
- POWERED to DENIED is *drop*.
- DENIED to IDLE is *release*.
- Any state to IDLE on supply overvoltage is *trip*.

Arbitration applies only while managed mode is enabled. When the supply flags that it cannot carry every contender, ports that contend at the same level are refused or dropped together. A port that contends at a level of its own is unaffected. Sticky status bits record supply overvoltage and undervoltage until the host clears them.

Top module: `prio_power_arbiter`

## Requirements
- R1: After reset every port field of `port_state` reads IDLE (2'b00) and `glob_status` reads 3'b000.
- R2: `port_state` holds port i at bits [2i+1:2i], with IDLE=2'b00, POWERED=2'b01 and DENIED=2'b10. With `managed_en` low, a `detect_done` pulse on an IDLE port powers it on the next cycle, whatever its priority, the floors or `supply_ok`. A powered port then stays POWERED.
- R3: `prio_lvls` holds port i's level at bits [2i+1:2i], with critical=3, high=2, medium=1 and low=0. With `managed_en` high, a detection on an IDLE port is a grant (next cycle POWERED) when its level is >= `grant_floor`. It is a refuse (next cycle DENIED) when its level is below `grant_floor`.
- R4: With `managed_en` high, the keep check runs on every clock. A POWERED port whose level is below `keep_floor` is DENIED on the next cycle. A level equal to the floor keeps power.
- R5: A DENIED port ignores detections and stays DENIED until its `deny_clr` bit pulses. It is then IDLE on the next cycle.
- R6: With `managed_en` high and `supply_ok` low, a port contends if it is POWERED and meets `keep_floor`, or if it is IDLE, detecting and meets `grant_floor`. When two or more ports contend at the same level, all of them go to DENIED on the next cycle. A sole contender at its level is still granted or kept.
- R7: While `ovp_flag` is high, every port is IDLE on the next cycle and detections are ignored. `glob_status` bit 1 is set on the next cycle.
- R8: `uvp_flag` sets `glob_status` bit 2 on the next cycle and leaves every port state unchanged. Bit 0 of `glob_status` always reads 0.
- R9: Status bits 1 and 2 stay set until `status_clr` pulses and read 0 on the cycle after the clear. When a flag and `status_clr` are high in the same cycle, the bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| managed_en | input | 1 | Enables priority arbitration |
| prio_lvls | input | 16 | Per-port two-bit priority level |
| grant_floor | input | 2 | Minimum level for power-up after detection |
| keep_floor | input | 2 | Minimum level for staying powered |
| detect_done | input | 8 | Per-port detection-complete pulse |
| deny_clr | input | 8 | Per-port release pulse for DENIED ports |
| supply_ok | input | 1 | High when the supply can carry every contender |
| ovp_flag | input | 1 | Supply overvoltage |
| uvp_flag | input | 1 | Supply undervoltage |
| status_clr | input | 1 | Clears sticky status bits |
| port_state | output | 16 | Per-port state, two bits each |
| glob_status | output | 3 | bit 1 overvoltage, bit 2 undervoltage, bit 0 zero |

## Verification
Every result of this block is registered once. A port state or status bit reflects the inputs of the cycle before, one rising edge after the stimulus is applied. The driver task applies each stimulus at a falling edge and queues the expected state and status. The monitor pops that item two nanoseconds after the next rising edge. Every comparison therefore lands exactly one cycle after its stimulus, and pulse inputs are dropped by the following step.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_POWERED = 2'b01,
        ST_DENIED  = 2'b10
    } port_st_e;
endpackage

// File: rtl/arb_level_clash.sv
module arb_level_clash #(
    parameter int NUM_PORTS = 8,
    parameter int LVL_W     = 2
) (
    input  logic [NUM_PORTS*LVL_W-1:0] prio_flat,
    input  logic [NUM_PORTS-1:0]       contend,
    output logic [(1<<LVL_W)-1:0]      clash
);
    localparam int NUM_LVL = 1 << LVL_W;

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        logic [NUM_PORTS-1:0] at_lvl;
        always_comb begin
            for (int i = 0; i < NUM_PORTS; i++) begin
                at_lvl[i] = contend[i] &&
                            (prio_flat[i*LVL_W +: LVL_W] == LVL_W'(l));
            end
        end
        assign clash[l] = ($countones(at_lvl) >= 2);
    end
endmodule

// File: rtl/arb_port_fsm.sv
module arb_port_fsm
    import arb_pkg::*;
#(
    parameter int LVL_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   managed,
    input  logic                   supply_ok,
    input  logic                   ovp,
    input  logic                   detect,
    input  logic                   release_req,
    input  logic [LVL_W-1:0]       prio,
    input  logic [LVL_W-1:0]       grant_floor,
    input  logic [LVL_W-1:0]       keep_floor,
    input  logic [(1<<LVL_W)-1:0]  clash,
    output port_st_e               state,
    output logic                   contend
);
    port_st_e nxt;
    logic     lost;
    logic     meets_grant;
    logic     meets_keep;

    assign meets_grant = (prio >= grant_floor);
    assign meets_keep  = (prio >= keep_floor);
    assign lost        = !supply_ok && clash[prio];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (!ovp && detect) begin
                    if (!managed || (meets_grant && !lost)) nxt = ST_POWERED;
                    else                                    nxt = ST_DENIED;
                end
            end
            ST_POWERED: begin
                if (ovp)                                    nxt = ST_IDLE;
                else if (managed && (!meets_keep || lost))  nxt = ST_DENIED;
            end
            ST_DENIED: begin
                if (ovp || release_req)                     nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        contend = 1'b0;
        unique case (state)
            ST_IDLE:    contend = managed && detect && meets_grant;
            ST_POWERED: contend = managed && meets_keep;
            ST_DENIED:  contend = 1'b0;
            default:    contend = 1'b0;
        endcase
    end

    // R7
    trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovp |=> (state == ST_IDLE));
    // R5
    denied_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DENIED && !release_req && !ovp) |=> (state == ST_DENIED));
    // R4
    keep_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POWERED && managed && !ovp && (prio < keep_floor))
        |=> (state == ST_DENIED));
    // R2
    unmanaged_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POWERED && !managed && !ovp) |=> (state == ST_POWERED));
    // R2
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != 2'b11);
endmodule

// File: rtl/arb_status_sticky.sv
module arb_status_sticky (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovp,
    input  logic       uvp,
    input  logic       clr,
    output logic [2:0] status
);
    logic ov_q;
    logic uv_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_q <= 1'b0;
            uv_q <= 1'b0;
        end else begin
            ov_q <= ovp || (ov_q && !clr);
            uv_q <= uvp || (uv_q && !clr);
        end
    end

    assign status = {uv_q, ov_q, 1'b0};

    // R9
    ov_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !clr) |=> status[1]);
    // R9
    uv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] && !clr) |=> status[2]);
    // R8
    uv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvp |=> status[2]);
endmodule

// File: rtl/prio_power_arbiter.sv
module prio_power_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int LVL_W     = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         managed_en,
    input  logic [NUM_PORTS*LVL_W-1:0]   prio_lvls,
    input  logic [LVL_W-1:0]             grant_floor,
    input  logic [LVL_W-1:0]             keep_floor,
    input  logic [NUM_PORTS-1:0]         detect_done,
    input  logic [NUM_PORTS-1:0]         deny_clr,
    input  logic                         supply_ok,
    input  logic                         ovp_flag,
    input  logic                         uvp_flag,
    input  logic                         status_clr,
    output logic [NUM_PORTS*2-1:0]       port_state,
    output logic [2:0]                   glob_status
);
    localparam int NUM_LVL = 1 << LVL_W;

    logic [NUM_PORTS-1:0] contend;
    logic [NUM_LVL-1:0]   clash;

    arb_level_clash #(.NUM_PORTS(NUM_PORTS), .LVL_W(LVL_W)) u_clash (
        .prio_flat (prio_lvls),
        .contend   (contend),
        .clash     (clash)
    );

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        port_st_e st;
        arb_port_fsm #(.LVL_W(LVL_W)) u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .managed     (managed_en),
            .supply_ok   (supply_ok),
            .ovp         (ovp_flag),
            .detect      (detect_done[i]),
            .release_req (deny_clr[i]),
            .prio        (prio_lvls[i*LVL_W +: LVL_W]),
            .grant_floor (grant_floor),
            .keep_floor  (keep_floor),
            .clash       (clash),
            .state       (st),
            .contend     (contend[i])
        );
        assign port_state[i*2 +: 2] = st;

        // R3
        refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st == ST_IDLE && managed_en && detect_done[i] && !ovp_flag &&
             (prio_lvls[i*LVL_W +: LVL_W] < grant_floor)) |=> (st == ST_DENIED));
    end

    arb_status_sticky u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .ovp    (ovp_flag),
        .uvp    (uvp_flag),
        .clr    (status_clr),
        .status (glob_status)
    );

    // R7
    ov_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_flag |=> (glob_status[1] && port_state == '0));
endmodule

// File: tb/prio_power_arbiter_tb.sv
`timescale 1ns/1ps
module prio_power_arbiter_tb;
    localparam time TCLK = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        managed_en = 1'b1;
    logic [15:0] prio_lvls = 16'h1E1B;
    logic [1:0]  grant_floor = 2'd0;
    logic [1:0]  keep_floor = 2'd0;
    logic [7:0]  detect_done = '0;
    logic [7:0]  deny_clr = '0;
    logic        supply_ok = 1'b1;
    logic        ovp_flag = 1'b0;
    logic        uvp_flag = 1'b0;
    logic        status_clr = 1'b0;
    logic [15:0] port_state;
    logic [2:0]  glob_status;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] st;
        logic [2:0]  stat;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #(TCLK/2) clk = ~clk;

    prio_power_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .managed_en(managed_en),
        .prio_lvls(prio_lvls), .grant_floor(grant_floor),
        .keep_floor(keep_floor), .detect_done(detect_done),
        .deny_clr(deny_clr), .supply_ok(supply_ok), .ovp_flag(ovp_flag),
        .uvp_flag(uvp_flag), .status_clr(status_clr),
        .port_state(port_state), .glob_status(glob_status)
    );

    // Port levels: p0=3 p1=2 p2=1 p3=0 p4=2 p5=3 p6=1 p7=0 -> 16'h1E1B
    task automatic step(input logic [7:0] det, input logic [7:0] clr,
                        input logic man, input logic [1:0] gf,
                        input logic [1:0] kf, input logic sok,
                        input logic ov, input logic uv, input logic sclr,
                        input logic [15:0] exp_st, input logic [2:0] exp_stat,
                        input string tag);
        exp_t it;
        @(negedge clk);
        detect_done = det;
        deny_clr    = clr;
        managed_en  = man;
        grant_floor = gf;
        keep_floor  = kf;
        supply_ok   = sok;
        ovp_flag    = ov;
        uvp_flag    = uv;
        status_clr  = sclr;
        it.st = exp_st;
        it.stat = exp_stat;
        it.tag = tag;
        sb.push_back(it);
    endtask

    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            checks++;
            if (port_state !== it.st || glob_status !== it.stat) begin
                failures++;
                $display("FAIL %s: state=%h status=%b expected state=%h status=%b",
                         it.tag, port_state, glob_status, it.st, it.stat);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(8'h00, 8'h00, 1, 0, 0, 1, 0, 0, 0, 16'h0000, 3'b000, "R1 reset");
        // R2 unmanaged: low-priority port3 powered despite floor 3
        step(8'h08, 8'h00, 0, 3, 0, 1, 0, 0, 0, 16'h0040, 3'b000, "R2 unmanaged grant");
        // R3 refuse: port2 level1 < floor2
        step(8'h04, 8'h00, 1, 2, 0, 1, 0, 0, 0, 16'h0060, 3'b000, "R3 refuse");
        // R3 grant: port1 level2 >= floor2
        step(8'h02, 8'h00, 1, 2, 0, 1, 0, 0, 0, 16'h0064, 3'b000, "R3 grant");
        // R4 keep floor raised to 1 drops port3 (level 0)
        step(8'h00, 8'h00, 1, 2, 1, 1, 0, 0, 0, 16'h00A4, 3'b000, "R4 drop");
        // R5 release port2
        step(8'h00, 8'h04, 1, 2, 1, 1, 0, 0, 0, 16'h0084, 3'b000, "R5 release");
        // R6 port1 (powered) and port4 (detecting) both level 2, supply short
        step(8'h10, 8'h00, 1, 2, 1, 0, 0, 0, 0, 16'h0288, 3'b000, "R6 clash");
        // R6 sole contender at level 3 still granted
        step(8'h01, 8'h00, 1, 2, 1, 0, 0, 0, 0, 16'h0289, 3'b000, "R6 sole level");
        // R5 release ports 1,3,4; R2 unmanaged keeps port0
        step(8'h00, 8'h1A, 0, 2, 3, 0, 0, 0, 0, 16'h0001, 3'b000, "R5 multi release");
        step(8'h08, 8'h00, 0, 2, 3, 0, 0, 0, 0, 16'h0041, 3'b000, "R2 unmanaged floors ignored");
        step(8'h00, 8'h00, 0, 2, 3, 0, 0, 0, 0, 16'h0041, 3'b000, "R2 unmanaged hold");
        // R7 overvoltage trips all, ignores detection on port5
        step(8'h20, 8'h00, 0, 0, 0, 1, 1, 0, 0, 16'h0000, 3'b010, "R7 trip");
        step(8'h20, 8'h00, 0, 0, 0, 1, 0, 0, 0, 16'h0400, 3'b010, "R9 ov sticky");
        // R8 undervoltage only flags
        step(8'h00, 8'h00, 0, 0, 0, 1, 0, 1, 0, 16'h0400, 3'b110, "R8 uvp");
        step(8'h00, 8'h00, 0, 0, 0, 1, 0, 0, 0, 16'h0400, 3'b110, "R9 both sticky");
        step(8'h00, 8'h00, 0, 0, 0, 1, 0, 0, 1, 16'h0400, 3'b000, "R9 clear");
        // R9 set wins over clear; R7 trip
        step(8'h00, 8'h00, 0, 0, 0, 1, 1, 0, 1, 16'h0000, 3'b010, "R9 set wins");
        step(8'h20, 8'h00, 0, 0, 0, 1, 0, 0, 0, 16'h0400, 3'b010, "R2 repower");
        // R3 refuse port7 at floor 3
        step(8'h80, 8'h00, 1, 3, 0, 1, 0, 0, 0, 16'h8400, 3'b010, "R3 refuse floor3");
        // R5 detection ignored while denied
        step(8'h80, 8'h00, 1, 0, 0, 1, 0, 0, 0, 16'h8400, 3'b010, "R5 detect ignored");
        step(8'h00, 8'h80, 1, 0, 0, 1, 0, 0, 0, 16'h0400, 3'b010, "R5 release port7");
        // R4 boundary: level equal to keep floor stays powered
        step(8'h00, 8'h00, 1, 0, 3, 1, 0, 0, 0, 16'h0400, 3'b010, "R4 equal floor");
        @(negedge clk);
        detect_done = '0;
        deny_clr = '0;
        status_clr = 1'b0;
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(TCLK * 5000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule